// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a (segment selector, offset) pair into a physical address using a small on-chip table of segment descriptors. Each descriptor holds a base address, a limit giving the highest legal offset, three permission bits and a valid flag. Software fills the table through a single write port, one descriptor per clock.

Each request is checked in three steps. The selector must name a valid descriptor inside the table. The offset must not exceed that descriptor's limit. The one-hot access type must be allowed by the descriptor's permission bits. If all three checks pass, the response carries base plus offset. If any check fails, it carries a 2-bit fault cause and a zero address. The response is registered and appears exactly one clock after the request. The block is meant to sit in front of a memory port: the response either feeds the physical address onward or raises an exception.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and rsp_paddr are all zero, and every descriptor is invalid, so any request made before the table is written faults with code 11.
- R2: rsp_valid in a cycle equals req_valid in the previous cycle. When rsp_valid is low, rsp_fault and rsp_paddr are zero.
- R3: A request that passes every check returns fault code 00 and rsp_paddr equal to base plus the zero-extended offset, taken modulo 2^PA_W (the sum wraps).
- R4: An offset equal to the limit is accepted. An offset greater than the limit faults with code 01.
- R5: Permission and access bit positions are bit 0 read, bit 1 write and bit 2 execute. The request faults with code 10 unless req_acc has exactly one bit set and that bit is also set in the descriptor's permissions.
- R6: A selector at or beyond NUM_SEG, or one that names a descriptor whose valid flag is clear, faults with code 11. When several checks fail, the fault reported follows the priority 11, then 01, then 10.
- R7: Whenever a response carries a nonzero fault code, rsp_paddr is zero.
- R8: When cfg_we is high, the descriptor at cfg_idx is written at the clock edge. A request in that same cycle sees the old contents. A write whose cfg_idx is at or beyond NUM_SEG changes no descriptor.
- R9: A descriptor with base 0, the all-ones limit and all permissions set maps every offset to the same physical address (identity mapping).
- R10: Selector 1 with base 0x2000 and limit 0x1FF translates offset 0xFF to 0x20FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | SEL_W | Descriptor index to write |
| cfg_base | input | PA_W | Base address to store |
| cfg_limit | input | OFF_W | Highest legal offset to store |
| cfg_perm | input | 3 | Permissions to store (bit 0 read, bit 1 write, bit 2 execute) |
| cfg_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Request present |
| req_sel | input | SEL_W | Segment selector |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 3 | One-hot access type, same bit positions as cfg_perm |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_fault | output | 2 | 00 none, 01 bounds, 10 permission, 11 invalid selector |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |

## Verification
A corrupted descriptor shows at the ports on the first request that uses it, one clock later: either a wrong address or a fault code that the reference table does not predict. A write that lands in the wrong slot, or that takes effect a cycle early, is caught because requests in the same cycle as the write and in the cycle after are compared against a model that updates only at the edge. An off-by-one in the limit comparison shows only at offset equal to limit or limit plus one, so those offsets are driven directly. A wrong order among the fault checks shows only when two checks fail at once, so requests that fail two checks together are driven as well.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int PERM_W = 3;
  localparam int ACC_RD = 0;
  localparam int ACC_WR = 1;
  localparam int ACC_EX = 2;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BOUNDS = 2'b01,
    FLT_PERM   = 2'b10,
    FLT_SEL    = 2'b11
  } fault_e;

  // Access allowed only for exactly one requested bit that is also granted.
  function automatic logic access_granted(input logic [PERM_W-1:0] acc,
                                          input logic [PERM_W-1:0] perm);
    return ($countones(acc) == 1) && ((acc & perm) != '0);
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int NUM_SEG = 8,
  parameter int SEL_W   = 4,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_idx,
  input  logic [PA_W-1:0]                   wr_base,
  input  logic [OFF_W-1:0]                  wr_limit,
  input  logic [seg_xlate_pkg::PERM_W-1:0]  wr_perm,
  input  logic                              wr_valid,
  input  logic [SEL_W-1:0]                  rd_sel,
  output logic                              rd_in_range,
  output logic                              rd_valid,
  output logic [PA_W-1:0]                   rd_base,
  output logic [OFF_W-1:0]                  rd_limit,
  output logic [seg_xlate_pkg::PERM_W-1:0]  rd_perm
);
  import seg_xlate_pkg::*;

  logic [PA_W-1:0]   base_q  [NUM_SEG];
  logic [OFF_W-1:0]  limit_q [NUM_SEG];
  logic [PERM_W-1:0] perm_q  [NUM_SEG];
  logic              valid_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        perm_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (hit_wr) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        perm_q[g]  <= wr_perm;
        valid_q[g] <= wr_valid;
      end
    end
  end

  always_comb begin
    rd_in_range = 1'b0;
    rd_valid    = 1'b0;
    rd_base     = '0;
    rd_limit    = '0;
    rd_perm     = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_in_range = 1'b1;
        rd_valid    = valid_q[i];
        rd_base     = base_q[i];
        rd_limit    = limit_q[i];
        rd_perm     = perm_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input  logic                              in_range,
  input  logic                              ent_valid,
  input  logic [PA_W-1:0]                   ent_base,
  input  logic [OFF_W-1:0]                  ent_limit,
  input  logic [seg_xlate_pkg::PERM_W-1:0]  ent_perm,
  input  logic [OFF_W-1:0]                  off,
  input  logic [seg_xlate_pkg::PERM_W-1:0]  acc,
  output logic                              sel_ok,
  output logic                              bound_ok,
  output logic                              perm_ok,
  output seg_xlate_pkg::fault_e             fault_nx,
  output logic [PA_W-1:0]                   paddr_nx
);
  import seg_xlate_pkg::*;

  function automatic logic within_limit(input logic [OFF_W-1:0] o,
                                        input logic [OFF_W-1:0] lim);
    return o <= lim;
  endfunction

  function automatic logic [PA_W-1:0] add_base(input logic [PA_W-1:0] b,
                                               input logic [OFF_W-1:0] o);
    return b + PA_W'(o);
  endfunction

  assign sel_ok   = in_range && ent_valid;
  assign bound_ok = within_limit(off, ent_limit);
  assign perm_ok  = access_granted(acc, ent_perm);

  always_comb begin
    if (!sel_ok)        fault_nx = FLT_SEL;
    else if (!bound_ok) fault_nx = FLT_BOUNDS;
    else if (!perm_ok)  fault_nx = FLT_PERM;
    else                fault_nx = FLT_NONE;
  end

  assign paddr_nx = (fault_nx == FLT_NONE) ? add_base(ent_base, off) : '0;
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int PA_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  seg_xlate_pkg::fault_e in_fault,
  input  logic [PA_W-1:0]       in_paddr,
  output logic                  out_valid,
  output logic [1:0]            out_fault,
  output logic [PA_W-1:0]       out_paddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 2'b00;
      out_paddr <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid ? in_fault : 2'b00;
      out_paddr <= in_valid ? in_paddr : '0;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NUM_SEG = 8,
  parameter int SEL_W   = 4,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_idx,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [OFF_W-1:0]  cfg_limit,
  input  logic [2:0]        cfg_perm,
  input  logic              cfg_valid,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [2:0]        req_acc,
  output logic              rsp_valid,
  output logic [1:0]        rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);
  import seg_xlate_pkg::*;

  logic              w_in_range;
  logic              w_ent_valid;
  logic [PA_W-1:0]   w_base;
  logic [OFF_W-1:0]  w_limit;
  logic [PERM_W-1:0] w_perm;
  logic              w_sel_ok;
  logic              w_bound_ok;
  logic              w_perm_ok;
  fault_e            w_fault_nx;
  logic [PA_W-1:0]   w_paddr_nx;

  seg_table #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base), .wr_limit(cfg_limit),
    .wr_perm(cfg_perm), .wr_valid(cfg_valid),
    .rd_sel(req_sel), .rd_in_range(w_in_range), .rd_valid(w_ent_valid),
    .rd_base(w_base), .rd_limit(w_limit), .rd_perm(w_perm)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .in_range(w_in_range), .ent_valid(w_ent_valid), .ent_base(w_base),
    .ent_limit(w_limit), .ent_perm(w_perm), .off(req_off), .acc(req_acc),
    .sel_ok(w_sel_ok), .bound_ok(w_bound_ok), .perm_ok(w_perm_ok),
    .fault_nx(w_fault_nx), .paddr_nx(w_paddr_nx)
  );

  seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_fault(w_fault_nx),
    .in_paddr(w_paddr_nx), .out_valid(rsp_valid), .out_fault(rsp_fault),
    .out_paddr(rsp_paddr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            sel_ok,
  input logic            bound_ok,
  input logic            perm_ok,
  input logic            rsp_valid,
  input logic [1:0]      rsp_fault,
  input logic [PA_W-1:0] rsp_paddr
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 2'b00 && rsp_paddr == '0));

  p_pass_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_ok && bound_ok && perm_ok) |=> rsp_fault == 2'b00);

  p_bounds_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_ok && !bound_ok) |=> rsp_fault == 2'b01);

  p_perm_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_ok && bound_ok && !perm_ok) |=> rsp_fault == 2'b10);

  p_sel_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_ok) |=> rsp_fault == 2'b11);

  p_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .sel_ok(w_sel_ok), .bound_ok(w_bound_ok), .perm_ok(w_perm_ok),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  localparam int NSEG = 8;
  localparam int SW   = 4;
  localparam int OW   = 16;
  localparam int PW   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0; logic [SW-1:0] cfg_idx = 0; logic [PW-1:0] cfg_base = 0;
  logic [OW-1:0] cfg_limit = 0; logic [2:0] cfg_perm = 0; logic cfg_valid = 0;
  logic req_valid = 0; logic [SW-1:0] req_sel = 0; logic [OW-1:0] req_off = 0;
  logic [2:0] req_acc = 0;
  logic rsp_valid; logic [1:0] rsp_fault; logic [PW-1:0] rsp_paddr;

  always #2 clk = ~clk;

  seg_xlate #(.NUM_SEG(NSEG), .SEL_W(SW), .OFF_W(OW), .PA_W(PW)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit armed = 0, done = 0;
  string cur_tag = "R1", exp_tag = "R1";

  // behavioural reference table
  longint m_base [NSEG];
  longint m_lim  [NSEG];
  int     m_perm [NSEG];
  bit     m_ok   [NSEG];
  bit exp_v; int exp_f; longint exp_pa;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ok[i]) begin m_ok[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0; end
      exp_v = 0; exp_f = 0; exp_pa = 0; exp_tag = "R1";
    end else begin
      int s; int bits;
      s = int'(req_sel);
      exp_tag = cur_tag;
      exp_v = req_valid; exp_f = 0; exp_pa = 0;
      if (req_valid) begin
        bits = (req_acc[0] ? 1 : 0) + (req_acc[1] ? 1 : 0) + (req_acc[2] ? 1 : 0);
        if (s >= NSEG) exp_f = 3;
        else if (!m_ok[s]) exp_f = 3;
        else if (longint'(req_off) > m_lim[s]) exp_f = 1;
        else if (bits != 1 || (int'(req_acc) & m_perm[s]) == 0) exp_f = 2;
        else exp_pa = (m_base[s] + longint'(req_off)) % (longint'(1) << PW);
      end
      if (cfg_we && int'(cfg_idx) < NSEG) begin
        m_base[cfg_idx] = longint'(cfg_base); m_lim[cfg_idx] = longint'(cfg_limit);
        m_perm[cfg_idx] = int'(cfg_perm); m_ok[cfg_idx] = cfg_valid;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      n_cmp++;
      if (rsp_valid !== exp_v || int'(rsp_fault) != exp_f || longint'(rsp_paddr) != exp_pa) begin
        n_bad++;
        $display("FAIL %s model: got v=%0b f=%0d pa=%h, expected v=%0b f=%0d pa=%h",
                 exp_tag, rsp_valid, rsp_fault, rsp_paddr, exp_v, exp_f, exp_pa);
      end
    end
  end

  task automatic drive(input bit we, input int idx, input longint b, input longint lim,
                       input int p, input bit v, input bit rv, input int sel,
                       input longint off, input int acc, input string tag);
    @(negedge clk);
    cfg_we = we; cfg_idx = SW'(idx); cfg_base = PW'(b); cfg_limit = OW'(lim);
    cfg_perm = 3'(p); cfg_valid = v;
    req_valid = rv; req_sel = SW'(sel); req_off = OW'(off); req_acc = 3'(acc);
    cur_tag = tag;
  endtask

  task automatic wr(input int idx, input longint b, input longint lim, input int p, input bit v);
    drive(1, idx, b, lim, p, v, 0, 0, 0, 0, "R8");
  endtask

  // issue a request, then check its response against a hand-computed value
  task automatic req_chk(input int sel, input longint off, input int acc, input string tag,
                         input int ef, input longint epa);
    drive(0, 0, 0, 0, 0, 0, 1, sel, off, acc, tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    n_cmp++;
    if (!rsp_valid || int'(rsp_fault) != ef || longint'(rsp_paddr) != epa) begin
      n_bad++;
      $display("FAIL %s direct: got v=%0b f=%0d pa=%h, expected v=1 f=%0d pa=%h",
               tag, rsp_valid, rsp_fault, rsp_paddr, ef, epa);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; armed = 1;
    // R1: reset state, R2: idle outputs quiet
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    req_chk(0, 16'h10, 1, "R1", 3, 0);
    req_chk(5, 16'h0, 4, "R1", 3, 0);
    // R10 example: read and write granted
    wr(1, 24'h2000, 16'h1FF, 3'b011, 1);
    req_chk(1, 16'hFF, 1, "R10", 0, 24'h20FF);
    // R4 limit edges
    req_chk(1, 16'h1FF, 1, "R4", 0, 24'h21FF);
    req_chk(1, 16'h200, 1, "R4", 1, 0);
    // R5 permissions
    req_chk(1, 16'h10, 2, "R5", 0, 24'h2010);
    req_chk(1, 16'h10, 4, "R5", 2, 0);
    req_chk(1, 16'h10, 3, "R5", 2, 0);
    req_chk(1, 16'h10, 0, "R5", 2, 0);
    // R6 selector faults and priority
    req_chk(9, 16'h0, 1, "R6", 3, 0);
    wr(2, 24'h4000, 16'hFFFF, 3'b111, 0);
    req_chk(2, 16'h0, 1, "R6", 3, 0);
    req_chk(1, 16'h300, 4, "R6", 1, 0);
    req_chk(12, 16'hFFFF, 0, "R6", 3, 0);
    // R3 wrapping sum
    wr(3, 24'hFFFFF0, 16'hFFFF, 3'b100, 1);
    req_chk(3, 16'h20, 4, "R3", 0, 24'h000010);
    // R9 identity mapping
    wr(0, 0, 16'hFFFF, 3'b111, 1);
    req_chk(0, 16'h0, 1, "R9", 0, 0);
    req_chk(0, 16'h1234, 2, "R9", 0, 24'h1234);
    req_chk(0, 16'hFFFF, 4, "R9", 0, 24'hFFFF);
    // R8 same-cycle write sees old contents, then new
    drive(1, 4, 24'h8000, 16'h0F, 1, 1, 1, 4, 16'h4, 1, "R8");
    drive(0, 0, 0, 0, 0, 0, 1, 4, 16'h4, 1, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    n_cmp++;
    if (int'(rsp_fault) != 0 || rsp_paddr != 24'h8004) begin
      n_bad++;
      $display("FAIL R8 direct: got f=%0d pa=%h, expected f=0 pa=008004", rsp_fault, rsp_paddr);
    end
    // R8 out-of-range write ignored: index 8 must not alias entry 0
    wr(8, 24'h5555, 16'h0, 3'b000, 1);
    req_chk(8, 16'h0, 1, "R8", 3, 0);
    req_chk(0, 16'h77, 1, "R8", 0, 24'h77);
    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      int accs[5] = '{1, 2, 4, 3, 0};
      drive(($urandom % 4) == 0, $urandom % 10, $urandom, $urandom % 16'h400,
            $urandom % 8, ($urandom % 5) != 0, ($urandom % 4) != 0, $urandom % 10,
            $urandom % 16'h500, accs[$urandom % 5], "R3");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule